// File: doc/BRIEF.md
# Reset Source Type Router

This block collects reset requests from three kinds of source: an external reset pin, a software reset command issued by the PLL controller, and a bank of watchdog timers. Each source has its own programmable type bit that makes its requests either hard or soft. The router turns a request into a fixed-length pulse on a hard-reset output or on a soft-reset output. The two outputs are never driven at the same time. If a hard and a soft request arrive in the same cycle, the hard request wins.

A per-module isolation mask selects modules whose clocking and PLL setup must survive resets other than power-on. When any mask bit is set, the pulse that would reset the PLL settings registers is suppressed. A module counts as fully isolated only when its mask bit and its own external isolation enable are both high. A small register bus reaches the type and isolation registers. Writes to the type register are accepted only after a correct unlock key has been written, and one key allows exactly one such write. Power-on reset overrides everything: it clears all registers and forces a hard reset that also resets the PLL settings.

Top module: `rst_type_router`

## Requirements
- R1: While porN is low, hardRst=1, softRst=0 and pllCfgRst=1, and every register reads 0. After porN rises, hardRst and pllCfgRst stay high until the PULSE_LEN-th rising clock edge and then fall.
- R2: After power-on every type bit is 0, so any single request produces a hard pulse.
- R3: The type register is at address 1. Bit i (i < NUM_WDOG) is the type of watchdog i, bit 8 is the type of the reset pin and bit 9 is the type of the PLL software request. A value of 1 means soft and 0 means hard.
- R4: Writing UNLOCK_KEY to address 0 arms one write to address 1. Writes to address 1 while not armed are ignored, and the first write to address 1 after arming disarms it.
- R5: Writing any value other than UNLOCK_KEY to address 0 clears a pending unlock.
- R6: When requests of both types are present in the same sampling cycle, a hard pulse is produced.
- R7: A request sampled at rising edge k raises the chosen output after edge k for exactly PULSE_LEN cycles. Requests sampled while a pulse is running are ignored.
- R8: hardRst and softRst are never high together.
- R9: pllCfgRst accompanies a pulse only if the isolation mask (address 2, bits [NUM_ISO-1:0]) was all zero when the pulse started.
- R10: modIsolated equals the isolation mask ANDed bitwise with isoEnable.
- R11: Reserved bits and address 3 read 0, and address 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous active-low power-on reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address (0 key, 1 type, 2 isolation) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| rstPinReq | input | 1 | External reset pin request |
| pllSwReq | input | 1 | PLL controller software reset request |
| wdogReq | input | NUM_WDOG | Watchdog reset requests |
| isoEnable | input | NUM_ISO | Per-module isolation enables |
| modIsolated | output | NUM_ISO | Modules fully isolated |
| hardRst | output | 1 | Hard reset pulse |
| softRst | output | 1 | Soft reset pulse |
| pllCfgRst | output | 1 | Reset to PLL settings registers |

## Verification
A wrong type bit, unlock flag or mask bit stays hidden until it is used. A corrupted type bit shows up as a pulse on the wrong output one cycle after the next request from that source. A stale unlock flag shows up as a type-register readback that changes when it should not. A miscounting pulse counter shows up on the falling edge of the pulse, PULSE_LEN cycles after the rise. A missed busy state shows up as an extra pulse that nothing requested. The scoreboard pairs each pulse with the request that caused it, so any of these faults is reported within one pulse length.

// File: rtl/rst_router_pkg.sv
package rst_router_pkg;
  typedef struct packed {
    logic startHard;
    logic startSoft;
    logic keepPll;
  } rstStrobe_t;

  localparam logic [1:0] ADDR_KEY  = 2'd0;
  localparam logic [1:0] ADDR_TYPE = 2'd1;
  localparam logic [1:0] ADDR_ISO  = 2'd2;
  localparam int PIN_TYPE_BIT = 8;
  localparam int PLL_TYPE_BIT = 9;
endpackage

// File: rtl/rst_router_ctrl.sv
module rst_router_ctrl
  import rst_router_pkg::*;
#(
  parameter int NUM_WDOG = 4,
  parameter int NUM_ISO = 3,
  parameter int DATA_W = 32,
  parameter logic [31:0] UNLOCK_KEY = 32'hC0DE_5EED
) (
  input  logic                clk,
  input  logic                porN,
  input  logic                busWrEn,
  input  logic [1:0]          busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic                rstPinReq,
  input  logic                pllSwReq,
  input  logic [NUM_WDOG-1:0] wdogReq,
  input  logic [NUM_ISO-1:0]  isoEnable,
  output logic [NUM_ISO-1:0]  modIsolated,
  output rstStrobe_t          strobe
);
  logic [NUM_WDOG-1:0] wdogType, wdHard, wdSoft;
  logic pinType, pllType, unlocked;
  logic [NUM_ISO-1:0] isoMask;
  logic [DATA_W-1:0] typeWord, isoWord;
  logic hardReq, softReq;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wdogType <= '0;
      pinType  <= 1'b0;
      pllType  <= 1'b0;
      isoMask  <= '0;
      unlocked <= 1'b0;
    end else if (busWrEn) begin
      case (busAddr)
        ADDR_KEY: unlocked <= (busWrData == DATA_W'(UNLOCK_KEY));
        ADDR_TYPE: if (unlocked) begin
          wdogType <= busWrData[NUM_WDOG-1:0];
          pinType  <= busWrData[PIN_TYPE_BIT];
          pllType  <= busWrData[PLL_TYPE_BIT];
          unlocked <= 1'b0;
        end
        ADDR_ISO: isoMask <= busWrData[NUM_ISO-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    typeWord = '0;
    typeWord[NUM_WDOG-1:0] = wdogType;
    typeWord[PIN_TYPE_BIT] = pinType;
    typeWord[PLL_TYPE_BIT] = pllType;
    isoWord = '0;
    isoWord[NUM_ISO-1:0] = isoMask;
    case (busAddr)
      ADDR_TYPE: busRdData = typeWord;
      ADDR_ISO:  busRdData = isoWord;
      default:   busRdData = '0;
    endcase
  end

  genvar i;
  for (i = 0; i < NUM_WDOG; i++) begin : g_wdClass
    assign wdHard[i] = wdogReq[i] & ~wdogType[i];
    assign wdSoft[i] = wdogReq[i] &  wdogType[i];
  end

  assign hardReq = (rstPinReq & ~pinType) | (pllSwReq & ~pllType) | (|wdHard);
  assign softReq = (rstPinReq &  pinType) | (pllSwReq &  pllType) | (|wdSoft);

  assign strobe.startHard = hardReq;
  assign strobe.startSoft = softReq & ~hardReq;
  assign strobe.keepPll   = |isoMask;
  assign modIsolated      = isoMask & isoEnable;

  p_locked_write_ignored_r4: assert property (@(posedge clk) disable iff (!porN)
    (busWrEn && busAddr == ADDR_TYPE && !unlocked) |=> $stable(typeWord));
  p_unlock_consumed_r4: assert property (@(posedge clk) disable iff (!porN)
    (busWrEn && busAddr == ADDR_TYPE) |=> !unlocked);
  p_wrong_key_relocks_r5: assert property (@(posedge clk) disable iff (!porN)
    (busWrEn && busAddr == ADDR_KEY && busWrData != DATA_W'(UNLOCK_KEY)) |=> !unlocked);
endmodule

// File: rtl/rst_router_pulse.sv
module rst_router_pulse
  import rst_router_pkg::*;
#(
  parameter int PULSE_LEN = 6
) (
  input  logic       clk,
  input  logic       porN,
  input  rstStrobe_t strobe,
  output logic       hardRst,
  output logic       softRst,
  output logic       pllCfgRst
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  logic [CNT_W-1:0] cnt;
  logic hardQ, softQ, pllQ;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      cnt   <= CNT_W'(PULSE_LEN);
      hardQ <= 1'b1;
      softQ <= 1'b0;
      pllQ  <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) begin
        hardQ <= 1'b0;
        softQ <= 1'b0;
        pllQ  <= 1'b0;
      end
    end else if (strobe.startHard || strobe.startSoft) begin
      cnt   <= CNT_W'(PULSE_LEN);
      hardQ <= strobe.startHard;
      softQ <= strobe.startSoft;
      pllQ  <= ~strobe.keepPll;
    end
  end

  assign hardRst   = hardQ;
  assign softRst   = softQ;
  assign pllCfgRst = pllQ;

  p_one_type_r8: assert property (@(posedge clk) disable iff (!porN) !(hardQ && softQ));
  p_pll_with_pulse_r9: assert property (@(posedge clk) disable iff (!porN)
    pllQ |-> (hardQ || softQ));
  p_hard_wins_r6: assert property (@(posedge clk) disable iff (!porN)
    (cnt == '0 && strobe.startHard) |=> (hardQ && !softQ));
  p_pulse_end_r7: assert property (@(posedge clk) disable iff (!porN)
    $fell(hardQ || softQ) |-> ($past(cnt) == CNT_W'(1)));
  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!porN)
    (cnt > CNT_W'(1)) |=> ($stable(hardQ) && $stable(softQ)));
endmodule

// File: rtl/rst_type_router.sv
module rst_type_router
  import rst_router_pkg::*;
#(
  parameter int NUM_WDOG = 4,
  parameter int NUM_ISO = 3,
  parameter int PULSE_LEN = 6,
  parameter logic [31:0] UNLOCK_KEY = 32'hC0DE_5EED
) (
  input  logic                clk,
  input  logic                porN,
  input  logic                busWrEn,
  input  logic [1:0]          busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic                rstPinReq,
  input  logic                pllSwReq,
  input  logic [NUM_WDOG-1:0] wdogReq,
  input  logic [NUM_ISO-1:0]  isoEnable,
  output logic [NUM_ISO-1:0]  modIsolated,
  output logic                hardRst,
  output logic                softRst,
  output logic                pllCfgRst
);
  rstStrobe_t strobe;

  rst_router_ctrl #(
    .NUM_WDOG(NUM_WDOG), .NUM_ISO(NUM_ISO), .DATA_W(32), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_ctrl (
    .clk(clk), .porN(porN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .rstPinReq(rstPinReq),
    .pllSwReq(pllSwReq), .wdogReq(wdogReq), .isoEnable(isoEnable),
    .modIsolated(modIsolated), .strobe(strobe)
  );

  rst_router_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .porN(porN), .strobe(strobe),
    .hardRst(hardRst), .softRst(softRst), .pllCfgRst(pllCfgRst)
  );
endmodule

// File: tb/rst_type_router_test.sv
module rst_type_router_test;
  localparam int NW = 4;
  localparam int NI = 3;
  localparam int L = 6;
  localparam logic [31:0] KEY = 32'hC0DE_5EED;

  logic clk, porN, busWrEn, rstPinReq, pllSwReq;
  logic [1:0] busAddr;
  logic [31:0] busWrData, busRdData;
  logic [NW-1:0] wdogReq;
  logic [NI-1:0] isoEnable, modIsolated;
  logic hardRst, softRst, pllCfgRst;

  int checks = 0;
  int fails = 0;
  logic [1:0] expQ[$];
  bit monEn = 0;
  bit prevAct = 0;
  int pulseLen = 0;
  logic [1:0] cur;

  rst_type_router #(.NUM_WDOG(NW), .NUM_ISO(NI), .PULSE_LEN(L), .UNLOCK_KEY(KEY)) uut (
    .clk(clk), .porN(porN), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .rstPinReq(rstPinReq), .pllSwReq(pllSwReq), .wdogReq(wdogReq),
    .isoEnable(isoEnable), .modIsolated(modIsolated), .hardRst(hardRst),
    .softRst(softRst), .pllCfgRst(pllCfgRst)
  );

  initial begin
    clk = 0;
    forever #4 clk = ~clk;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected {isHard, pll} item on each pulse rise
  always @(negedge clk) begin
    if (monEn) begin
      if (hardRst && softRst) chk(0, "R8 both outputs high", {hardRst, softRst}, 2'b10);
      if ((hardRst || softRst) && !prevAct) begin
        if (expQ.size() == 0) chk(0, "R7 unexpected pulse", {hardRst, pllCfgRst}, 0);
        else begin
          cur = expQ.pop_front();
          chk({hardRst, pllCfgRst} == cur && softRst == !cur[1],
              "R2/R3/R6/R9 pulse type", {softRst, hardRst, pllCfgRst}, {!cur[1], cur});
        end
        pulseLen = 1;
      end else if (hardRst || softRst) pulseLen++;
      else if (prevAct) chk(pulseLen == L, "R7 pulse length", pulseLen, L);
      prevAct = hardRst || softRst;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 0;
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    #1;
    chk(busRdData == exp, tag, busRdData, exp);
  endtask

  task automatic fire(input bit pin, input bit pll, input logic [NW-1:0] wd,
                      input bit expHard, input bit expPll);
    expQ.push_back({expHard, expPll});
    @(negedge clk);
    rstPinReq = pin; pllSwReq = pll; wdogReq = wd;
    @(negedge clk);
    rstPinReq = 0; pllSwReq = 0; wdogReq = '0;
    repeat (L + 2) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int cnt;
    porN = 1; busWrEn = 0; busAddr = 0; busWrData = 0;
    rstPinReq = 0; pllSwReq = 0; wdogReq = '0; isoEnable = '0;
    #1 porN = 0;
    repeat (3) @(negedge clk);
    chk(hardRst && !softRst && pllCfgRst, "R1 reset outputs", {hardRst, softRst, pllCfgRst}, 3'b101);
    rdChk(2'd1, 0, "R1 type reg cleared");
    rdChk(2'd2, 0, "R1 iso reg cleared");
    @(negedge clk);
    #2 porN = 1;
    cnt = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!hardRst) break;
      cnt++;
    end
    chk(cnt == L - 1, "R1 power-on pulse length", cnt, L - 1);
    chk(!pllCfgRst && !softRst, "R1 outputs fall", {softRst, pllCfgRst}, 0);
    monEn = 1;

    // R2 defaults hard
    fire(1, 0, '0, 1, 1);
    fire(0, 0, 4'b0100, 1, 1);
    fire(0, 1, '0, 1, 1);

    // R4 locked write ignored
    wr(2'd1, 32'h0000_03FF);
    rdChk(2'd1, 0, "R4 locked write ignored");
    wr(2'd0, KEY);
    wr(2'd1, 32'h0000_F102);
    rdChk(2'd1, 32'h0000_0102, "R4 unlocked write, R11 reserved bits zero");
    wr(2'd1, 32'h0000_03FF);
    rdChk(2'd1, 32'h0000_0102, "R4 unlock consumed");
    rdChk(2'd0, 0, "R11 key address reads zero");
    rdChk(2'd3, 0, "R11 unused address reads zero");

    // R3 per-source types
    fire(1, 0, '0, 0, 1);
    fire(0, 0, 4'b0010, 0, 1);
    fire(0, 0, 4'b0001, 1, 1);
    fire(0, 1, '0, 1, 1);
    // R6 mixed types in one cycle
    fire(1, 0, 4'b0001, 1, 1);

    // R5 wrong key clears pending unlock
    wr(2'd0, KEY);
    wr(2'd0, KEY ^ 32'h1);
    wr(2'd1, 32'h0000_0302);
    rdChk(2'd1, 32'h0000_0102, "R5 wrong key relocks");
    wr(2'd0, KEY);
    wr(2'd1, 32'h0000_0302);
    rdChk(2'd1, 32'h0000_0302, "R3 pll type bit 9");
    fire(0, 1, '0, 0, 1);

    // R9 / R10 isolation
    wr(2'd2, 32'hFFFF_FFFA);
    rdChk(2'd2, 32'h0000_0002, "R11 iso reserved bits zero");
    isoEnable = 3'b011;
    #1 chk(modIsolated == 3'b010, "R10 isolated modules", modIsolated, 3'b010);
    isoEnable = 3'b101;
    #1 chk(modIsolated == 3'b000, "R10 enable without mask", modIsolated, 3'b000);
    fire(1, 0, '0, 0, 0);
    fire(0, 0, 4'b0001, 1, 0);
    wr(2'd2, 0);
    fire(0, 0, 4'b0001, 1, 1);

    // R7 requests during a running pulse are ignored
    expQ.push_back(2'b11);
    @(negedge clk);
    wdogReq = 4'b1000;
    @(negedge clk);
    wdogReq = '0;
    repeat (2) @(negedge clk);
    rstPinReq = 1;
    @(negedge clk);
    rstPinReq = 0;
    repeat (L + 4) @(negedge clk);
    chk(expQ.size() == 0, "R7 all expected pulses seen", expQ.size(), 0);
    chk(!hardRst && !softRst, "R7 idle after busy request", {hardRst, softRst}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule